// File: doc/BRIEF.md
# Three-level event interrupt controller

This block gathers single-cycle event pulses from up to 96 hardware sources into three 32-bit sticky status words. Once a bit is set it stays set until software acknowledges it by writing a one to that bit position. Writing a zero to a bit leaves it alone.

Three independent mask banks sit beside the shared status words. Each bank holds three 32-bit words and drives one interrupt output to the host CPU. Level 0 is the most urgent output and level 2 the least urgent.

For each level, the block also reports a registered vector: a valid flag and the number of the lowest-numbered event that is both pending and enabled in that level's bank. Software reaches all registers through a plain 32-bit bus with address, write enable, write data and combinational read data.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset all status words and all mask words read zero, and every `irq_o`, `vec_valid_o` and `vec_idx_o` bit is zero.
- R2: A one-cycle pulse on `evt_i[e]` sets bit `e%32` of the status word at byte address `4*(e/32)` (0x00, 0x04, 0x08). The bit stays set with no further pulse.
- R3: A bus write to a status word clears every bit written as one and keeps every bit written as zero.
- R4: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Mask word `w` of level `g` is read and written in full at byte address `0x10*(g+1) + 4*w`, so level 0 uses 0x10–0x18, level 1 uses 0x20–0x28 and level 2 uses 0x30–0x38.
- R6: `irq_o[g]` is high exactly one clock after some status bit and the matching level-`g` mask bit are both set. Bit 0 is the most urgent level and bit 2 the least urgent.
- R7: A pending status bit whose mask bit is zero in a level raises neither that level's interrupt nor its vector.
- R8: `vec_valid_o[g]` follows `irq_o[g]`. `vec_idx_o[7*g +: 7]` holds the lowest enabled pending event number, computed as word index times 32 plus bit position, with the same one-clock latency. It is zero when the level has nothing pending.
- R9: Reads from addresses that map to no register return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 96 | Event pulses, one per source |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 3 | Registered interrupt per level, bit 0 most urgent |
| vec_valid_o | output | 3 | Registered per-level vector valid |
| vec_idx_o | output | 21 | Per-level 7-bit lowest pending event number |

## Verification
The bench aims at the cases where ordering and selection are easy to get wrong:
- **Same-cycle set and clear.** A design where the clear wins would drop a real event.
- **Write-one-to-clear with zero bits.** A design that overwrote the status word, instead of masking the clear, would wipe unrelated pending events.
- **Selection across words.** An event in word 0 must beat one in word 2, so an encoder scanning from the top, or word by word in the wrong order, reports the wrong number.
- **Masking.** Pending but masked events must stay silent, and clearing a mask must drop the line. A design that skipped the mask would raise spurious interrupts.

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl #(
  parameter int NW     = 3,
  parameter int NL     = 3,
  parameter int WORD_W = 32,
  parameter int AW     = 8,
  parameter int IW     = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NW*WORD_W-1:0] evt_i,
  input  logic [AW-1:0]        bus_addr,
  input  logic                 bus_we,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NL-1:0]        irq_o,
  output logic [NL-1:0]        vec_valid_o,
  output logic [NL*IW-1:0]     vec_idx_o
);
  localparam int NE = NW * WORD_W;

  logic [NE-1:0] st;
  logic [NE-1:0] clr;
  logic [NE-1:0] msk  [NL];
  logic [NE-1:0] qual [NL];
  logic [NL-1:0] irq_q, vld_q, nxt_vld;
  logic [IW-1:0] idx_q [NL];
  logic [IW-1:0] nxt_idx [NL];

  always_comb begin
    clr = '0;
    for (int w = 0; w < NW; w++)
      if (bus_we && bus_addr == AW'(4 * w))
        clr[w*WORD_W +: WORD_W] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr) | evt_i;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < NL; g++)
      for (int w = 0; w < NW; w++)
        if (!rst_n)
          msk[g][w*WORD_W +: WORD_W] <= '0;
        else if (bus_we && bus_addr == AW'(16 * (g + 1) + 4 * w))
          msk[g][w*WORD_W +: WORD_W] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < NW; w++)
      if (bus_addr == AW'(4 * w)) bus_rdata = st[w*WORD_W +: WORD_W];
    for (int g = 0; g < NL; g++)
      for (int w = 0; w < NW; w++)
        if (bus_addr == AW'(16 * (g + 1) + 4 * w))
          bus_rdata = msk[g][w*WORD_W +: WORD_W];
  end

  generate
    for (genvar g = 0; g < NL; g++) begin : g_lvl
      assign qual[g] = st & msk[g];

      always_comb begin
        nxt_vld[g] = 1'b0;
        nxt_idx[g] = '0;
        for (int e = NE - 1; e >= 0; e--)
          if (qual[g][e]) begin
            nxt_vld[g] = 1'b1;
            nxt_idx[g] = IW'(e);
          end
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          irq_q[g] <= 1'b0;
          vld_q[g] <= 1'b0;
          idx_q[g] <= '0;
        end else begin
          irq_q[g] <= |qual[g];
          vld_q[g] <= nxt_vld[g];
          idx_q[g] <= nxt_idx[g];
        end
      end

      assign vec_idx_o[g*IW +: IW] = idx_q[g];

      assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q[g] == $past(|qual[g]));

      assert_vld_matches_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[g] == irq_q[g]);

      assert_lowest_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[g] |-> ((|($past(qual[g]) & (NE'(1) << idx_q[g]))) &&
                      (($past(qual[g]) & ((NE'(1) << idx_q[g]) - NE'(1))) == '0)));
    end
  endgenerate

  assign irq_o       = irq_q;
  assign vec_valid_o = vld_q;

  assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(st) & ~st & ~$past(clr)) == '0));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_i) & ~st) == '0));
endmodule

// File: tb/evt_irq_ctrl_test.sv
module evt_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] evt_i = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o, vec_valid_o;
  logic [20:0] vec_idx_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .vec_valid_o(vec_valid_o), .vec_idx_o(vec_idx_o));

  localparam logic [1:0] WR = 2'd0, EV = 2'd1, RD = 2'd2, CK = 2'd3;

  function automatic logic [31:0] ckv(logic [2:0] irq, int i0, int i1, int i2);
    return {8'd0, 3'(0), 7'(i2), 7'(i1), 7'(i0), irq} >> 0;
  endfunction

  localparam int NV = 25;
  // entry: {req, op, addr, data}
  localparam logic [45:0] TBL [NV] = '{
    {4'd1, RD, 8'h00, 32'h0},                 // R1
    {4'd1, RD, 8'h10, 32'h0},                 // R1
    {4'd1, CK, 8'h00, 32'h0},                 // R1
    {4'd2, EV, 8'h00, 32'd5},
    {4'd2, RD, 8'h00, 32'h20},                // R2
    {4'd7, CK, 8'h00, 32'h0},                 // R7 pending but masked
    {4'd5, WR, 8'h10, 32'h20},
    {4'd5, RD, 8'h10, 32'h20},                // R5
    {4'd6, CK, 8'h00, ckv(3'b001, 5, 0, 0)},  // R6
    {4'd2, EV, 8'h00, 32'd40},
    {4'd2, RD, 8'h04, 32'h100},               // R2
    {4'd5, WR, 8'h24, 32'h100},
    {4'd8, CK, 8'h00, ckv(3'b011, 5, 40, 0)}, // R8
    {4'd2, EV, 8'h00, 32'd70},
    {4'd2, EV, 8'h00, 32'd66},
    {4'd5, WR, 8'h38, 32'h44},
    {4'd5, WR, 8'h30, 32'h20},
    {4'd8, CK, 8'h00, ckv(3'b111, 5, 40, 5)}, // R8 word 0 beats word 2
    {4'd3, WR, 8'h00, 32'h20},
    {4'd3, RD, 8'h00, 32'h0},                 // R3
    {4'd8, CK, 8'h00, ckv(3'b110, 0, 40, 66)},// R8
    {4'd3, WR, 8'h08, 32'h0},
    {4'd3, RD, 8'h08, 32'h44},                // R3 zero bits keep
    {4'd9, RD, 8'h0C, 32'h0},                 // R9
    {4'd9, RD, 8'h3C, 32'h0}                  // R9
  };

  task automatic chk(bit ok, int req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int req, logic [1:0] op, logic [7:0] a, logic [31:0] d);
    case (op)
      WR: begin
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
      end
      EV: begin
        evt_i[d] = 1'b1;
        @(negedge clk); evt_i = '0;
      end
      RD: begin
        bus_addr = a; #1;
        chk(bus_rdata == d, req, bus_rdata, d);
      end
      default: begin
        @(negedge clk);
        chk({vec_idx_o, irq_o} == d[23:0] && vec_valid_o == d[2:0], req,
            {8'd0, vec_idx_o, vec_valid_o}, d);
      end
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++)
      step(int'(TBL[i][45:42]), TBL[i][41:40], TBL[i][39:32], TBL[i][31:0]);

    // R3: clear 66, leaving 70 as lowest for level 2
    step(3, WR, 8'h08, 32'h4);
    step(3, RD, 8'h08, 32'h40);
    step(8, CK, 8'h00, ckv(3'b110, 0, 40, 70));

    // R4: pulse on event 33 while its bit is written to clear
    bus_addr = 8'h04; bus_wdata = 32'h2; bus_we = 1'b1; evt_i[33] = 1'b1;
    @(negedge clk); bus_we = 1'b0; evt_i = '0;
    step(4, RD, 8'h04, 32'h102);
    step(3, WR, 8'h04, 32'h102);
    step(3, RD, 8'h04, 32'h0);
    step(8, CK, 8'h00, ckv(3'b100, 0, 0, 70));

    // R7: masking the last enabled bit drops the line while status stays
    step(7, WR, 8'h38, 32'h0);
    step(7, CK, 8'h00, 32'h0);
    step(7, RD, 8'h08, 32'h40);

    // R1: reset in mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1, RD, 8'h08, 32'h0);
    step(1, RD, 8'h24, 32'h0);
    chk({irq_o, vec_valid_o, vec_idx_o} == '0, 1, {5'd0, irq_o, vec_valid_o, vec_idx_o}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R0: watchdog expired actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule